// File: doc/BRIEF.md
# PHY Receive/Transmit Error Statistics Counters

This block keeps five 16-bit error statistics for a 10/100 Ethernet physical layer. Each counter sits at its own management register address. The counters cover the following events:

- 100 Mb/s frames that arrived damaged
- individual receive symbol errors
- 100 Mb/s frames cut short
- 10 Mb/s end-of-frame faults
- 10 Mb/s transmit jabber detections

Line decoding logic supplies single-cycle event strobes, together with frame start and frame end markers. A management agent reads the statistics through a plain read port. The port takes an address and a read strobe, and it returns registered read data one cycle later.

Every counter stops at full scale and never wraps. Reading a counter hands back its value and clears it in the same step. The damaged-frame statistic is kept per frame. A per-frame flag collects symbol errors and early-end events while the frame is in progress. The counter then advances once, when the frame closes, if that flag shows any fault. This holds however many faults the frame carried.

Top module: `phy_err_stats`

## Requirements
- R1: The read address picks the counter. Address 21 is damaged frames, 22 is symbol errors, 23 is 100 Mb/s early ends, 24 is 10 Mb/s end-of-frame faults and 25 is jabber detections. The value appears on rd_data bits 15:0 in the cycle after the read strobe.
- R2: After reset, every counter reads zero.
- R3: A counter at 0xFFFF stays at 0xFFFF when further events arrive.
- R4: A read clears only the counter it addresses. The other counters keep their values.
- R5: An event on the same cycle as a read of its counter does not get lost. The read returns the value from before the event, and the counter then holds 1.
- R6: The damaged-frame counter advances by exactly one when frm_end is seen. It does so only if the frame had at least one sym_err or rx_early_eof since frm_start, counting the frm_end cycle itself. A frm_start discards any errors seen before it.
- R7: The symbol, early-end, 10 Mb/s end-of-frame and jabber counters each advance by one for every cycle their strobe is high.
- R8: A read of any address outside 21 to 25 returns zero and changes no counter.
- R9: rd_data is zero in every cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_start | input | 1 | First cycle of a received 100 Mb/s frame |
| frm_end | input | 1 | Closing cycle of a received 100 Mb/s frame |
| sym_err | input | 1 | Receive symbol error strobe |
| rx_early_eof | input | 1 | 100 Mb/s premature end-of-frame strobe |
| eof_err_10 | input | 1 | 10 Mb/s end-of-frame error strobe |
| jabber_det | input | 1 | 10 Mb/s transmit jabber detection strobe |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 5 | Register address of the read |
| rd_data | output | 16 | Registered read data |

## Verification
The bench places an event in the same cycle as a read of its own counter. A design that simply zeroes the counter on a read would lose that event and then read back 0 instead of 1.

It sends frames with several symbol errors, a clean frame that follows a stray error, and frames whose fault lands in the frm_end cycle. These catch three faults:
- a design that counts every error instead of every frame;
- a design that keeps a stale flag across frm_start;
- a design that misses a same-cycle fault.

Reading one counter and then a neighbour shows whether a clear spreads beyond the addressed register. Holding jabber high for more than 65535 cycles shows whether a counter wraps back to a small value.

// File: rtl/phy_err_stats.sv
module phy_err_stats #(
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 5,
  parameter int BASE_ADDR = 21,
  parameter int N_CNT     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_start,
  input  logic              frm_end,
  input  logic              sym_err,
  input  logic              rx_early_eof,
  input  logic              eof_err_10,
  input  logic              jabber_det,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data
);

  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic             bad_q;
  logic             frame_bad;
  logic [N_CNT-1:0] inc;
  logic [N_CNT-1:0] hit;
  logic [CNT_W-1:0] cnt_q [N_CNT];
  logic [CNT_W-1:0] sel;

  assign frame_bad = frm_end & (bad_q | sym_err | rx_early_eof);
  assign inc = {jabber_det, eof_err_10, rx_early_eof, sym_err, frame_bad};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bad_q <= 1'b0;
    else if (frm_end)   bad_q <= 1'b0;
    else if (frm_start) bad_q <= sym_err | rx_early_eof;
    else                bad_q <= bad_q | sym_err | rx_early_eof;
  end

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    assign hit[i] = rd_en && (rd_addr == ADDR_W'(BASE_ADDR + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q[i] <= '0;
      else if (hit[i])                  cnt_q[i] <= {{(CNT_W-1){1'b0}}, inc[i]};
      else if (inc[i] && cnt_q[i] != FULL) cnt_q[i] <= cnt_q[i] + 1'b1;
    end

    p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[i] == FULL && !hit[i]) |=> cnt_q[i] == FULL);
    p_clear_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && !inc[i]) |=> cnt_q[i] == '0);
    p_race_keeps_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && inc[i]) |=> cnt_q[i] == CNT_W'(1));
    p_no_event_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit[i] && !inc[i]) |=> $stable(cnt_q[i]));
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < N_CNT; i++)
      if (hit[i]) sel = cnt_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= sel;
  end

  p_one_hit_r1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rd_data == '0);
  p_frame_only_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_end && !hit[0]) |=> $stable(cnt_q[0]));

endmodule

// File: tb/phy_err_stats_tb_top.sv
`timescale 1ns/1ps
module phy_err_stats_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        frm_start = 0, frm_end = 0, sym_err = 0, rx_early_eof = 0;
  logic        eof_err_10 = 0, jabber_det = 0, rd_en = 0;
  logic [4:0]  rd_addr = 0;
  logic [15:0] rd_data;
  int n_chk = 0, n_fail = 0;
  logic [15:0] v;

  always #2.5 clk = ~clk;

  phy_err_stats dut_i (.clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_end(frm_end),
    .sym_err(sym_err), .rx_early_eof(rx_early_eof), .eof_err_10(eof_err_10),
    .jabber_det(jabber_det), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic clear_all();
    for (int a = 21; a <= 25; a++) rd(5'(a), v);
  endtask

  task automatic cyc(input logic fs, fe, se, ee, e10, jb);
    @(negedge clk);
    frm_start = fs; frm_end = fe; sym_err = se; rx_early_eof = ee; eof_err_10 = e10; jabber_det = jb;
    @(negedge clk);
    frm_start = 0; frm_end = 0; sym_err = 0; rx_early_eof = 0; eof_err_10 = 0; jabber_det = 0;
  endtask

  task automatic t_reset();
    for (int a = 21; a <= 25; a++) begin rd(5'(a), v); check("R2", v, 16'h0); end
  endtask

  task automatic t_frames();
    clear_all();
    cyc(1,0,0,0,0,0); cyc(0,0,1,0,0,0); cyc(0,0,1,0,0,0); cyc(0,0,1,0,0,0); cyc(0,1,0,0,0,0);
    cyc(0,0,1,0,0,0); cyc(1,0,0,0,0,0); cyc(0,0,0,0,0,0); cyc(0,1,0,0,0,0);
    cyc(1,0,0,0,0,0); cyc(0,1,0,1,0,0);
    cyc(1,0,0,0,0,0); cyc(0,1,1,0,0,0);
    rd(5'd21, v); check("R6 frame count", v, 16'd3);
    rd(5'd22, v); check("R7 symbol count", v, 16'd5);
    rd(5'd23, v); check("R7 early eof count", v, 16'd1);
  endtask

  task automatic t_map();
    clear_all();
    cyc(0,0,1,0,0,0);
    repeat (2) cyc(0,0,0,1,0,0);
    repeat (3) cyc(0,0,0,0,1,0);
    repeat (4) cyc(0,0,0,0,0,1);
    rd(5'd22, v); check("R1 addr22", v, 16'd1);
    rd(5'd23, v); check("R1 addr23", v, 16'd2);
    rd(5'd24, v); check("R1 addr24", v, 16'd3);
    rd(5'd25, v); check("R1 addr25", v, 16'd4);
  endtask

  task automatic t_only_addressed();
    clear_all();
    cyc(0,0,0,0,1,1);
    rd(5'd24, v); check("R4 first read", v, 16'd1);
    rd(5'd25, v); check("R4 neighbour kept", v, 16'd1);
    rd(5'd24, v); check("R4 cleared", v, 16'd0);
  endtask

  task automatic t_other_addr();
    clear_all();
    repeat (2) cyc(0,0,0,0,0,1);
    rd(5'd20, v); check("R8 addr20", v, 16'd0);
    rd(5'd26, v); check("R8 addr26", v, 16'd0);
    rd(5'd25, v); check("R8 counter intact", v, 16'd2);
  endtask

  task automatic t_race();
    clear_all();
    repeat (2) cyc(0,0,1,0,0,0);
    @(negedge clk); rd_en = 1; rd_addr = 5'd22; sym_err = 1;
    @(negedge clk); rd_en = 0; sym_err = 0; v = rd_data;
    check("R5 old value", v, 16'd2);
    rd(5'd22, v); check("R5 counter holds 1", v, 16'd1);
  endtask

  task automatic t_idle();
    rd(5'd25, v);
    @(negedge clk); check("R9 idle data", rd_data, 16'h0);
  endtask

  task automatic t_saturate();
    clear_all();
    @(negedge clk); jabber_det = 1;
    repeat (65540) @(negedge clk);
    jabber_det = 0;
    rd(5'd25, v); check("R3 saturated", v, 16'hFFFF);
    rd(5'd25, v); check("R3 cleared after full", v, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_frames();
    t_map();
    t_only_addressed();
    t_other_addr();
    t_race();
    t_idle();
    t_saturate();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(190000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule